// File: doc/BRIEF.md
# I/O Aperture Port-Address Remapper

This block sits on the bus of a 32-bit processor and claims a fixed 8 MB window of physical addresses starting at 0x80000000. Every access that lands inside the window is turned into a 16-bit legacy I/O port address and is handed to the downstream port bus, one clock later, with its direction, size code and write data. The data path also swaps byte lanes for a big-endian master, both on write data going out and on read data coming back.

A one-bit mapping-mode register, written and read through a small configuration port, selects how window offsets become port numbers. In dense mode the low 16 bits of the offset are the port number, so the window repeats a 64 KB port space. In sparse mode each 4 KB page of the window carries 32 consecutive ports. The port number is then made from offset bits [4:0] (low five bits) and offset bits [22:12] (port bits [15:5]), so that register groups spread across pages pack into one dense port space. The downstream devices are not part of this block.

Top module: `io_window_remap`

## Requirements
- R1: During and right after reset, `portValid` is 0 and the mapping mode is dense, so `cfgRdata` reads 0x00.
- R2: In dense mode (mode bit 0) the port address is offset[15:0], where offset = reqAddr - 0x80000000. Offsets at or above 0x10000 wrap modulo 64 KB.
- R3: In sparse mode (mode bit 1) the port address is {offset[22:12], offset[4:0]}, which equals (offset & 0x1F) | ((offset & 0x7FF000) >> 7).
- R4: A configuration write keeps only bit 0 of `cfgWdata` as the mode bit. `cfgRdata` returns {7'b0, mode}. The mode changes only on a configuration write.
- R5: A request whose address lies outside 0x80000000..0x807FFFFF produces no port strobe.
- R6: Size code 2'b01 (halfword) swaps the two low bytes of the write data and clears the upper 16 bits: out = {16'h0, d[7:0], d[15:8]}.
- R7: Size code 2'b10 (word) fully reverses the write data: out = {d[7:0], d[15:8], d[23:16], d[31:24]}.
- R8: Size code 2'b00 (byte), and the unused code 2'b11, pass the data through unswapped.
- R9: `reqRdata` applies the same lane rule as R6 to R8 to `isaRdata`, using the size of the access currently on the port bus.
- R10: A request accepted at a clock edge appears on the port outputs at that same edge and is held for exactly one cycle. The outputs carry the request's direction and size code unchanged. Back-to-back requests give back-to-back strobes.
- R11: If a configuration write and a window access arrive in the same cycle, the access is translated with the mode held before the write. The next access uses the new mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Processor access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Physical byte address |
| reqSize | input | 2 | 00 byte, 01 half, 10 word |
| reqWdata | input | 32 | Write data from the master |
| reqRdata | output | 32 | Lane-adjusted read data to the master |
| cfgWe | input | 1 | Mapping-mode register write strobe |
| cfgWdata | input | 8 | Mapping-mode register write data |
| cfgRdata | output | 8 | Mapping-mode register readback |
| portValid | output | 1 | Port bus strobe, one cycle per access |
| portWrite | output | 1 | Port bus direction |
| portAddr | output | 16 | Translated I/O port address |
| portSize | output | 2 | Access size code |
| portWdata | output | 32 | Lane-adjusted write data |
| isaRdata | input | 32 | Read data from the port bus |

## Verification
The one same-cycle hazard is a mode-register write that coincides with a window access. The access must still use the old mode, and the following access must use the new one. The bench drives both strobes on the same clock edge while the mode is sparse and writes dense. The scoreboard then expects the sparse port number for that access and the dense number for the next access, issued back to back. A register that applied the write first would give a different port address for the first of the two.

// File: rtl/io_remap_pkg.sv
package io_remap_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } accSize_e;

  // Strobes from control to datapath for the current cycle
  typedef struct packed {
    logic       hit;     // access falls in the window
    logic       write;
    logic [1:0] size;
    logic       sparse;  // mode held before any same-cycle config write
  } remapStrb_t;

  // Byte-lane adjustment for a big-endian master
  function automatic logic [31:0] laneSwap(input logic [31:0] d, input logic [1:0] sz);
    logic [31:0] r;
    case (sz)
      SZ_HALF: r = {16'h0000, d[7:0], d[15:8]};
      SZ_WORD: r = {d[7:0], d[15:8], d[23:16], d[31:24]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/io_remap_ctrl.sv
module io_remap_ctrl
  import io_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int APERTURE_BITS = 23,
  parameter logic [ADDR_W-1:0] APERTURE_BASE = 32'h8000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output remapStrb_t        strb
);
  localparam int TAG_W = ADDR_W - APERTURE_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = APERTURE_BASE[ADDR_W-1:APERTURE_BITS];

  logic mapSparse;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      mapSparse <= 1'b0;
    else if (cfgWe) mapSparse <= cfgWdata[0];
  end

  assign cfgRdata = {7'b0, mapSparse};

  always_comb begin
    strb.hit    = reqValid && (reqAddr[ADDR_W-1:APERTURE_BITS] == WIN_TAG);
    strb.write  = reqWrite;
    strb.size   = reqSize;
    strb.sparse = mapSparse;
  end

  // R4: mode register moves only on a configuration write
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(cfgWe) |-> $stable(cfgRdata));

  // R4: after a write the readback reflects bit 0 of the written value
  p_mode_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWe) |-> cfgRdata == {7'b0, $past(cfgWdata[0])});

endmodule

// File: rtl/io_remap_datapath.sv
module io_remap_datapath
  import io_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int APERTURE_BITS = 23,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] APERTURE_BASE = 32'h8000_0000,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  remapStrb_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWdata,
  input  logic [31:0]       isaRdata,
  output logic [31:0]       reqRdata,
  output logic              portValid,
  output logic              portWrite,
  output logic [PORT_W-1:0] portAddr,
  output logic [1:0]        portSize,
  output logic [31:0]       portWdata
);
  localparam int HI_W  = APERTURE_BITS - PAGE_SHIFT;   // page-number bits kept
  localparam int LOW_W = PORT_W - HI_W;                // ports per page (log2)
  localparam int TAG_W = ADDR_W - APERTURE_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = APERTURE_BASE[ADDR_W-1:APERTURE_BITS];

  logic [APERTURE_BITS-1:0] offset;
  logic [PORT_W-1:0]        densePort, sparsePort, nextPort;
  logic [31:0]              nextWdata;

  assign offset     = reqAddr[APERTURE_BITS-1:0];
  assign densePort  = offset[PORT_W-1:0];
  assign sparsePort = {offset[APERTURE_BITS-1:PAGE_SHIFT], offset[LOW_W-1:0]};
  assign nextPort   = strb.sparse ? sparsePort : densePort;

  generate
    if (BIG_ENDIAN) begin : g_swap
      assign nextWdata = laneSwap(reqWdata, strb.size);
      assign reqRdata  = laneSwap(isaRdata, portSize);
    end else begin : g_pass
      assign nextWdata = reqWdata;
      assign reqRdata  = isaRdata;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      portValid <= 1'b0;
      portWrite <= 1'b0;
      portAddr  <= '0;
      portSize  <= 2'b00;
      portWdata <= '0;
    end else begin
      portValid <= strb.hit;
      if (strb.hit) begin
        portWrite <= strb.write;
        portAddr  <= nextPort;
        portSize  <= strb.size;
        portWdata <= nextWdata;
      end
    end
  end

  // R10: a strobe follows a request at the previous edge
  p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rstN)
    portValid |-> $past(strb.hit));

  // R5: only window addresses reach the port bus
  p_in_window_r5: assert property (@(posedge clk) disable iff (!rstN)
    portValid |-> $past(reqAddr[ADDR_W-1:APERTURE_BITS]) == WIN_TAG);

  // R8: byte writes leave the data lanes untouched
  p_byte_noswap_r8: assert property (@(posedge clk) disable iff (!rstN)
    (portValid && portWrite && portSize == SZ_BYTE) |-> portWdata == $past(reqWdata));

  // R3: low port bits always come from the low offset bits
  p_low_bits_r3: assert property (@(posedge clk) disable iff (!rstN)
    portValid |-> portAddr[LOW_W-1:0] == $past(reqAddr[LOW_W-1:0]));

endmodule

// File: rtl/io_window_remap.sv
module io_window_remap
  import io_remap_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PORT_W = 16,
  parameter int APERTURE_BITS = 23,
  parameter int PAGE_SHIFT = 12,
  parameter logic [ADDR_W-1:0] APERTURE_BASE = 32'h8000_0000,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic [31:0]       reqRdata,
  input  logic              cfgWe,
  input  logic [7:0]        cfgWdata,
  output logic [7:0]        cfgRdata,
  output logic              portValid,
  output logic              portWrite,
  output logic [PORT_W-1:0] portAddr,
  output logic [1:0]        portSize,
  output logic [31:0]       portWdata,
  input  logic [31:0]       isaRdata
);
  remapStrb_t strb;

  io_remap_ctrl #(
    .ADDR_W(ADDR_W), .APERTURE_BITS(APERTURE_BITS), .APERTURE_BASE(APERTURE_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .strb(strb)
  );

  io_remap_datapath #(
    .ADDR_W(ADDR_W), .PORT_W(PORT_W), .APERTURE_BITS(APERTURE_BITS),
    .PAGE_SHIFT(PAGE_SHIFT), .APERTURE_BASE(APERTURE_BASE), .BIG_ENDIAN(BIG_ENDIAN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .isaRdata(isaRdata), .reqRdata(reqRdata), .portValid(portValid),
    .portWrite(portWrite), .portAddr(portAddr), .portSize(portSize),
    .portWdata(portWdata)
  );

endmodule

// File: tb/io_window_remap_tb.sv
`timescale 1ns/1ps
module io_window_remap_tb;

  typedef struct {
    logic [15:0] addr;
    logic [1:0]  size;
    logic        wr;
    logic [31:0] wdata;
    string       tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, cfgWe = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0, isaRdata = '0;
  logic [1:0]  reqSize = 2'b00;
  logic [7:0]  cfgWdata = '0;
  logic [31:0] reqRdata, portWdata;
  logic [7:0]  cfgRdata;
  logic        portValid, portWrite;
  logic [15:0] portAddr;
  logic [1:0]  portSize;

  int nChecks = 0, nFails = 0;
  logic tbSparse = 1'b0;
  expItem_t expQ[$];
  bit done = 1'b0;

  always #4 clk = ~clk;

  io_window_remap u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata), .reqRdata(reqRdata),
    .cfgWe(cfgWe), .cfgWdata(cfgWdata), .cfgRdata(cfgRdata),
    .portValid(portValid), .portWrite(portWrite), .portAddr(portAddr),
    .portSize(portSize), .portWdata(portWdata), .isaRdata(isaRdata)
  );

  function automatic logic [31:0] tbSwap(logic [31:0] d, logic [1:0] sz);
    logic [7:0] b [4];
    for (int i = 0; i < 4; i++) b[i] = d[8*i +: 8];
    case (sz)
      2'b01:   return {16'h0000, b[0], b[1]};
      2'b10:   return {b[0], b[1], b[2], b[3]};
      default: return d;
    endcase
  endfunction

  function automatic logic [15:0] tbPort(logic [31:0] a, logic sparse);
    logic [31:0] off;
    logic [31:0] p;
    off = a - 32'h8000_0000;
    if (sparse) p = (off & 32'h1F) | ((off & 32'h007F_F000) >> 7);
    else        p = off & 32'hFFFF;
    return p[15:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Driver: one request per call, expectation pushed for window hits
  task automatic issue(logic [31:0] a, logic [1:0] sz, logic wr, logic [31:0] d,
                       logic cfgW, logic [7:0] cfgD, string tag);
    expItem_t it;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqSize = sz; reqWrite = wr; reqWdata = d;
    cfgWe = cfgW; cfgWdata = cfgD;
    if (a >= 32'h8000_0000 && a < 32'h8080_0000) begin
      it.addr = tbPort(a, tbSparse); it.size = sz; it.wr = wr;
      it.wdata = tbSwap(d, sz); it.tag = tag;
      expQ.push_back(it);
    end
    if (cfgW) tbSparse = cfgD[0];
  endtask

  task automatic idle();
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b0;
  endtask

  task automatic cfgWrite(logic [7:0] v, logic [7:0] expRd, string tag);
    @(negedge clk);
    reqValid = 1'b0; cfgWe = 1'b1; cfgWdata = v;
    tbSparse = v[0];
    @(negedge clk);
    cfgWe = 1'b0;
    check(cfgRdata == expRd, tag, {24'h0, cfgRdata}, {24'h0, expRd});
  endtask

  // Monitor / scoreboard
  always @(posedge clk) begin
    #1;
    if (rstN && portValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5/R10 unexpected strobe", {16'h0, portAddr}, 32'h0);
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        check(portAddr == e.addr, {e.tag, " port address"}, {16'h0, portAddr}, {16'h0, e.addr});
        check(portSize == e.size && portWrite == e.wr, "R10 size/direction",
              {29'h0, portWrite, portSize}, {29'h0, e.wr, e.size});
        check(portWdata == e.wdata, {e.tag, " write data"}, portWdata, e.wdata);
      end
    end
  end

  // Watchdog
  initial begin
    #200000;
    if (!done) begin
      check(1'b0, "watchdog", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(portValid == 1'b0, "R1 valid in reset", {31'h0, portValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(portValid == 1'b0, "R1 valid after reset", {31'h0, portValid}, 32'h0);
    check(cfgRdata == 8'h00, "R1 mode after reset", {24'h0, cfgRdata}, 32'h0);

    // R2 dense, R8 byte, R6 half, R7 word, back-to-back for R10
    issue(32'h8000_03F8, 2'b00, 1'b1, 32'hA1B2_C3D4, 1'b0, 8'h00, "R2 R8");
    issue(32'h8012_3456, 2'b01, 1'b1, 32'h1122_3344, 1'b0, 8'h00, "R2 wrap R6");
    issue(32'h8000_FFFC, 2'b10, 1'b1, 32'hDEAD_BEEF, 1'b0, 8'h00, "R2 R7");
    issue(32'h8000_0061, 2'b11, 1'b0, 32'h5566_7788, 1'b0, 8'h00, "R8 rsvd");
    idle();
    @(negedge clk);
    check(portValid == 1'b0, "R10 strobe lasts one cycle", {31'h0, portValid}, 32'h0);

    // R5: outside the window
    issue(32'h7FFF_FFFC, 2'b10, 1'b1, 32'h0, 1'b0, 8'h00, "R5");
    issue(32'h8080_0000, 2'b00, 1'b1, 32'h0, 1'b0, 8'h00, "R5");
    idle();
    check(portValid == 1'b0, "R5 no strobe outside window", {31'h0, portValid}, 32'h0);

    // R4: only bit 0 kept
    cfgWrite(8'hFE, 8'h00, "R4 write FE");
    cfgWrite(8'hFF, 8'h01, "R4 write FF");

    // R3 sparse
    issue(32'h8001_F01C, 2'b10, 1'b1, 32'h0102_0304, 1'b0, 8'h00, "R3 R7");
    issue(32'h807F_F01F, 2'b00, 1'b1, 32'h0000_00AA, 1'b0, 8'h00, "R3 top");
    issue(32'h8000_1020, 2'b01, 1'b1, 32'hCAFE_F00D, 1'b0, 8'h00, "R3 alias R6");

    // R11: config write and access together; old mode applies, then new
    issue(32'h8003_4005, 2'b00, 1'b1, 32'h0000_0011, 1'b1, 8'h00, "R11 old mode");
    issue(32'h8003_4005, 2'b00, 1'b1, 32'h0000_0022, 1'b0, 8'h00, "R11 new mode");
    idle();
    check(cfgRdata == 8'h00, "R11 mode after same-cycle write", {24'h0, cfgRdata}, 32'h0);

    // R9: read data lane rule uses size of access on port bus
    begin
      logic [1:0] szs [3];
      szs[0] = 2'b01; szs[1] = 2'b10; szs[2] = 2'b00;
      for (int k = 0; k < 3; k++) begin
        isaRdata = 32'h9ABC_DEF0 + k;
        issue(32'h8000_0100, szs[k], 1'b0, 32'h0, 1'b0, 8'h00, "R9 read");
        idle();
        #1;
        check(reqRdata == tbSwap(isaRdata, szs[k]), "R9 read data", reqRdata,
              tbSwap(isaRdata, szs[k]));
      end
    end

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R10 all expected strobes seen", expQ.size(), 32'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule